// File: doc/BRIEF.md
# Register-Mapped GPIO Port with Atomic Set and Clear

This block is a general-purpose I/O port behind a simple bus slave. It has one output latch as wide as the data register, and every latch bit drives one output pin. A bus write to the data register replaces all pin levels at once. A read of the data register returns the levels seen on the input pins, after a two-flop synchroniser.

A build option adds two write-only mask registers, and they always come as a pair. Ones written to the first mask drive the matching pins high. Ones written to the second mask drive them low. Zero bits in either mask leave their pins alone. Software can therefore change single lines without a read-modify-write sequence.

The register width may be 8, 16, 32 or 64 bits, and the pin count equals that width. No line has a direction setting. A second build option picks how pins are numbered for a per-pin debug view. In normal order pin n is register bit n. In reversed order pin n is register bit WIDTH-1-n.

Top module: `mmio_gpio_port`

## Requirements
- R1: In the cycle after synchronous reset is released, `pin_out` and `bus_rdata` are all zeros.
- R2: A write (`bus_valid`=1, `bus_write`=1) to byte address 0 loads `bus_wdata` into the whole latch, and the new value is on `pin_out` after that clock edge.
- R3: A read (`bus_valid`=1, `bus_write`=0) of address 0 loads `bus_rdata` at that edge with the synchronised value of `pin_in`. The synchroniser's second flop is sampled, so a value on `pin_in` appears in a read whose strobe edge is at least two edges after the value was first captured. `bus_rdata` holds its value until the next read.
- R4: With set/clear present, a write to address DATA_W/8 sets to 1 every latch bit whose `bus_wdata` bit is 1. Bits written as 0 keep their value.
- R5: With set/clear present, a write to address 2*DATA_W/8 clears to 0 every latch bit whose `bus_wdata` bit is 1. Bits written as 0 keep their value.
- R6: A read of the set address or the clear address returns zero.
- R7: With set/clear absent, writes to those two addresses leave `pin_out` unchanged, and reads of them return zero.
- R8: A write to any other address, and any cycle with `bus_valid`=0, leaves `pin_out` unchanged. A read of any other address returns zero.
- R9: `pin_view[n]` equals `pin_out[n]` when PIN_REVERSE=0, and equals `pin_out[DATA_W-1-n]` when PIN_REVERSE=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data or mask |
| bus_rdata | output | DATA_W | Registered read data |
| pin_in | input | DATA_W | Asynchronous pin levels for readback |
| pin_out | output | DATA_W | Output latch, in register bit order |
| pin_view | output | DATA_W | Latch reordered by pin number |

## Verification
The assertions assume that each access lasts a single cycle with `bus_addr` and `bus_wdata` stable in that cycle, and that the address width holds all three offsets. The assertions make no assumption about `pin_in` timing. Only the readback checks need `pin_in` to have been stable for at least two edges before a read of address 0. The stimulus therefore changes `pin_in` only at falling edges, and waits the synchroniser latency before any read it compares. The one exception is a directed case that reads early on purpose and expects the old value.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_SET  = 2'd2,
    SEL_CLR  = 2'd3
  } reg_sel_e;

  function automatic int unsigned set_offset(input int unsigned width);
    return width / 8;
  endfunction

  function automatic int unsigned clr_offset(input int unsigned width);
    return 2 * (width / 8);
  endfunction

endpackage

// File: rtl/gpio_decode.sv
module gpio_decode
  import gpio_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter bit          HAS_SETCLR = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam logic [ADDR_W-1:0] DATA_A = '0;
  localparam logic [ADDR_W-1:0] SET_A  = ADDR_W'(set_offset(DATA_W));
  localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'(clr_offset(DATA_W));

  always_comb begin
    sel = SEL_NONE;
    if (addr == DATA_A)
      sel = SEL_DATA;
    else if (HAS_SETCLR && addr == SET_A)
      sel = SEL_SET;
    else if (HAS_SETCLR && addr == CLR_A)
      sel = SEL_CLR;
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] chain [STAGES];

  always_ff @(posedge clk) chain[0] <= d;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) chain[s] <= chain[s-1];
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_latch.sv
module gpio_latch
  import gpio_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_next;

  always_comb begin
    q_next = q;
    if (wr_en) begin
      unique case (sel)
        SEL_DATA: q_next = wdata;
        SEL_SET:  q_next = q | wdata;
        SEL_CLR:  q_next = q & ~wdata;
        default:  q_next = q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_next;
  end
endmodule

// File: rtl/gpio_view.sv
module gpio_view #(
  parameter int unsigned DATA_W      = 32,
  parameter bit          PIN_REVERSE = 1'b0
) (
  input  logic [DATA_W-1:0] regbits,
  output logic [DATA_W-1:0] pins
);
  for (genvar n = 0; n < DATA_W; n++) begin : g_pin
    if (PIN_REVERSE) begin : g_rev
      assign pins[n] = regbits[DATA_W-1-n];
    end else begin : g_fwd
      assign pins[n] = regbits[n];
    end
  end
endmodule

// File: rtl/mmio_gpio_port.sv
module mmio_gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter bit          HAS_SETCLR  = 1'b1,
  parameter bit          PIN_REVERSE = 1'b0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] pin_view
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] pin_sync;
  logic              wr_en;
  logic              rd_en;

  assign wr_en = bus_valid &  bus_write;
  assign rd_en = bus_valid & ~bus_write;

  gpio_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .HAS_SETCLR(HAS_SETCLR)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  gpio_latch #(.DATA_W(DATA_W)) u_latch (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .sel   (sel),
    .wdata (bus_wdata),
    .q     (pin_out)
  );

  gpio_sync #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (pin_in),
    .q   (pin_sync)
  );

  gpio_view #(.DATA_W(DATA_W), .PIN_REVERSE(PIN_REVERSE)) u_view (
    .regbits (pin_out),
    .pins    (pin_view)
  );

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (rd_en)
      bus_rdata <= (sel == SEL_DATA) ? pin_sync : '0;
  end
endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter bit          HAS_SETCLR = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] pin_out
);
  localparam logic [ADDR_W-1:0] A_DAT = '0;
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(DATA_W / 8);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(2 * (DATA_W / 8));

  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (pin_out == '0 && bus_rdata == '0));

  a_r2_data_load: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && bus_addr == A_DAT) |=> pin_out == $past(bus_wdata));

  a_r4_set_ones: assert property (@(posedge clk) disable iff (rst)
    (HAS_SETCLR && bus_valid && bus_write && bus_addr == A_SET)
      |=> (pin_out & $past(bus_wdata)) == $past(bus_wdata));

  a_r5_clr_ones: assert property (@(posedge clk) disable iff (rst)
    (HAS_SETCLR && bus_valid && bus_write && bus_addr == A_CLR)
      |=> (pin_out & $past(bus_wdata)) == '0);

  a_r6_mask_read_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && (bus_addr == A_SET || bus_addr == A_CLR))
      |=> bus_rdata == '0);

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && bus_write) |=> $stable(pin_out));
endmodule

bind mmio_gpio_port gpio_port_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .HAS_SETCLR(HAS_SETCLR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out)
);

// File: tb/sim_mmio_gpio_port.sv
`timescale 1ns/1ps
module sim_mmio_gpio_port;
  localparam int W  = 16;
  localparam int AW = 8;
  localparam int W1 = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          v, we;
  logic [AW-1:0] a;
  logic [W-1:0]  wd, rd, pin_in, pout, pview;

  logic          v1, we1;
  logic [AW-1:0] a1;
  logic [W1-1:0] wd1, rd1, pin_in1, pout1, pview1;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [W-1:0] exp_out = '0;

  mmio_gpio_port #(.DATA_W(W), .ADDR_W(AW), .HAS_SETCLR(1'b1), .PIN_REVERSE(1'b1)) u0 (
    .clk(clk), .rst(rst), .bus_valid(v), .bus_write(we), .bus_addr(a),
    .bus_wdata(wd), .bus_rdata(rd), .pin_in(pin_in), .pin_out(pout), .pin_view(pview));

  mmio_gpio_port #(.DATA_W(W1), .ADDR_W(AW), .HAS_SETCLR(1'b0), .PIN_REVERSE(1'b0)) u1 (
    .clk(clk), .rst(rst), .bus_valid(v1), .bus_write(we1), .bus_addr(a1),
    .bus_wdata(wd1), .bus_rdata(rd1), .pin_in(pin_in1), .pin_out(pout1), .pin_view(pview1));

  function automatic logic [W-1:0] rev16(input logic [W-1:0] x);
    logic [W-1:0] r;
    for (int n = 0; n < W; n++) r[n] = x[W-1-n];
    return r;
  endfunction

  function automatic logic [W-1:0] model_next(input logic [W-1:0] cur, input logic [AW-1:0] ad,
                                              input logic [W-1:0] d);
    if (ad == 0) return d;
    if (ad == AW'(W/8)) return cur | d;
    if (ad == AW'(2*W/8)) return cur & ~d;
    return cur;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [AW-1:0] ad, input logic [W-1:0] d);
    @(negedge clk);
    v = 1'b1; we = w; a = ad; wd = d;
    @(negedge clk);
    v = 1'b0; we = 1'b0;
    if (w) exp_out = model_next(exp_out, ad, d);
  endtask

  task automatic acc1(input logic w, input logic [AW-1:0] ad, input logic [W1-1:0] d);
    @(negedge clk);
    v1 = 1'b1; we1 = w; a1 = ad; wd1 = d;
    @(negedge clk);
    v1 = 1'b0; we1 = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    v = 0; we = 0; a = '0; wd = '0; pin_in = '0;
    v1 = 0; we1 = 0; a1 = '0; wd1 = '0; pin_in1 = '0;
    void'($urandom(32'h1234_5678));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 pin_out", pout, 0);
    check("R1 rdata", rd, 0);
    check("R1 u1 pin_out", pout1, 0);

    // R2 data write
    acc(1, 0, 16'hA5C3);
    check("R2 data write", pout, exp_out);
    // R9 reversed view
    check("R9 reversed view", pview, rev16(16'hA5C3));
    // R4 set
    acc(1, 2, 16'h0F00);
    check("R4 set", pout, 16'hAFC3);
    // R5 clr
    acc(1, 4, 16'h00C1);
    check("R5 clr", pout, 16'hAF02);
    // R6 mask reads
    acc(0, 2, 0);
    check("R6 set reads zero", rd, 0);
    acc(0, 4, 0);
    check("R6 clr reads zero", rd, 0);
    // R8 unmapped write and read
    acc(1, 6, 16'hFFFF);
    check("R8 unmapped write", pout, 16'hAF02);
    acc(1, 1, 16'h0000);
    check("R8 odd address write", pout, 16'hAF02);
    acc(0, 6, 0);
    check("R8 unmapped read", rd, 0);
    // R8 valid low
    @(negedge clk); we = 1; a = 0; wd = 16'h1111;
    @(negedge clk); we = 0;
    check("R8 valid low", pout, 16'hAF02);

    // R3 readback and sync latency
    pin_in = 16'h3C3C;
    repeat (3) @(negedge clk);
    acc(0, 0, 0);
    check("R3 readback", rd, 16'h3C3C);
    pin_in = 16'hBEEF;
    acc(0, 0, 0);
    check("R3 early read old", rd, 16'h3C3C);
    acc(0, 0, 0);
    check("R3 late read new", rd, 16'hBEEF);
    acc(1, 0, 16'h0000);
    check("R3 rdata held", rd, 16'hBEEF);

    // u1: no set/clear, normal order
    acc1(1, 0, 8'hA5);
    check("R2 u1 data", pout1, 8'hA5);
    check("R9 u1 normal view", pview1, 8'hA5);
    acc1(1, 1, 8'hFF);
    check("R7 u1 set ignored", pout1, 8'hA5);
    acc1(1, 2, 8'hFF);
    check("R7 u1 clr ignored", pout1, 8'hA5);
    pin_in1 = 8'h5A;
    repeat (3) @(negedge clk);
    acc1(0, 1, 0);
    check("R7 u1 set read zero", rd1, 0);
    acc1(0, 0, 0);
    check("R3 u1 readback", rd1, 8'h5A);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      logic [AW-1:0] ad;
      logic [W-1:0] d;
      op = 3'($urandom_range(0, 5));
      d  = W'($urandom);
      case (op)
        3'd0: ad = 0;
        3'd1: ad = 2;
        3'd2: ad = 4;
        3'd3: ad = AW'($urandom_range(5, 255));
        default: ad = 0;
      endcase
      if (op == 3'd4) begin
        pin_in = d;
        repeat (2) @(negedge clk);
        acc(0, 0, 0);
        check("R3 random read", rd, d);
      end else if (op == 3'd5) begin
        acc(0, AW'($urandom_range(1, 255)), 0);
        check("R6 R8 random read zero", rd, 0);
      end else begin
        acc(1, ad, d);
        check("R2 R4 R5 R8 random write", pout, exp_out);
        check("R9 random view", pview, rev16(exp_out));
      end
    end
    finish_run();
  end
endmodule